// File: doc/BRIEF.md
# Carry-Free Signed-Digit Adder

This block adds two N-digit signed-digit numbers in purely combinational logic. Every operand digit is -1, 0 or +1, held in a 2-bit code. The digit at position k has weight 2^k. No carry chain runs the width of the word. The sum is built in three steps. The first step splits each operand digit pair into a transfer and a weight. The second step rebalances each weight plus the incoming transfer into a second transfer and weight. The last step adds each second weight to the second transfer from the position below. The last step can never leave the digit range.

Because of this, every output digit is a fixed-depth function of at most three operand positions: its own and the two below it. Logic depth does not depend on N. The result has N+1 digits in the same 2-bit code, so the full sum of any two legal operands fits. The block holds no state and has no clock. It is meant to sit between registers of the enclosing datapath.

Top module: `msd_adder`

## Requirements
- R1: Digit code is 2'b00 = 0, 2'b01 = +1 and 2'b11 = -1, with digit k in bits [2k+1:2k]. The output never contains 2'b10.
- R2: For all legal operands, the sum over k of z_k·2^k (N+1 digits) equals the sum over k of (x_k + y_k)·2^k.
- R3: In the first step, a pair sum p gives the transfer and weight (T, W) as follows: p=+2 gives (+1, 0); p=+1 gives (+1, -1); p=0 gives (0, 0); p=-1 gives (-1, +1); p=-2 gives (-1, 0). With only position 0 non-zero, z_0 = W and z_1 = T, and all higher digits are 0.
- R4: In the second step, s = W_k + T_{k-1} gives (T1, W1) as follows: s=±2 gives (±1, 0); s=±1 gives (0, s); s=0 gives (0, 0). Worked cases: x = +1 at digit 0 gives z_0=-1 and z_1=+1. The operands x=(x1=-1, x0=+1) with y0=+1 give an all-zero result, and so does the mirror case.
- R5: A change to operand digits at position m changes no output digit outside positions m, m+1 and m+2.
- R6: z_0 depends only on x_0 and y_0. It is -1 when x_0+y_0=+1, it is +1 when x_0+y_0=-1, and otherwise it is 0.
- R7: The top digit z_N depends only on operand positions N-1 and N-2.
- R8: Zero plus zero gives the all-zero code. x plus its digit-wise negation gives the all-zero code.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| x_i | input | 2*N | First operand, N digits, digit k in bits [2k+1:2k] |
| y_i | input | 2*N | Second operand, same layout |
| z_o | output | 2*N+2 | Sum, N+1 digits, same layout |

## Verification
The interesting overlap is a second-step transfer that lands on a position whose own rebalanced weight is non-zero with the opposite sign. Two carry-free mechanisms then act on the same output digit. The overlap is provoked by placing a +2 pair below a -1 pair, and also by the mirrored signs. It is judged by an exact all-zero digit pattern, with no illegal code. An exhaustive N=4 sweep and a random N=16 sweep compare the decoded values. They also catch every other such collision, because any out-of-range digit either shows up as code 2'b10 or breaks the value sum.

// File: rtl/msd_pkg.sv
package msd_pkg;
  typedef logic [1:0] dcode_t;
  typedef logic signed [2:0] dval_t;
  typedef struct packed {
    dval_t t;
    dval_t w;
  } tw_t;

  localparam dcode_t CODE_ZERO = 2'b00;
  localparam dcode_t CODE_POS  = 2'b01;
  localparam dcode_t CODE_NEG  = 2'b11;

  function automatic dval_t dig_dec(dcode_t c);
    case (c)
      CODE_POS: return 3'sd1;
      CODE_NEG: return -3'sd1;
      default:  return 3'sd0;
    endcase
  endfunction

  function automatic dcode_t dig_enc(dval_t v);
    if (v > 3'sd0) return CODE_POS;
    if (v < 3'sd0) return CODE_NEG;
    return CODE_ZERO;
  endfunction

  // first step: odd pair sums leave a weight of opposite sign
  function automatic tw_t split_pair(dval_t s);
    tw_t r;
    case (s)
      3'sd2:   begin r.t = 3'sd1;  r.w = 3'sd0;  end
      3'sd1:   begin r.t = 3'sd1;  r.w = -3'sd1; end
      -3'sd1:  begin r.t = -3'sd1; r.w = 3'sd1;  end
      -3'sd2:  begin r.t = -3'sd1; r.w = 3'sd0;  end
      default: begin r.t = 3'sd0;  r.w = 3'sd0;  end
    endcase
    return r;
  endfunction

  // second step: only a magnitude-2 sum moves up a position
  function automatic tw_t split_sum(dval_t s);
    tw_t r;
    case (s)
      3'sd2:   begin r.t = 3'sd1;  r.w = 3'sd0; end
      -3'sd2:  begin r.t = -3'sd1; r.w = 3'sd0; end
      default: begin r.t = 3'sd0;  r.w = s;     end
    endcase
    return r;
  endfunction
endpackage

// File: rtl/msd_xfer_stage.sv
module msd_xfer_stage import msd_pkg::*; #(
  parameter int unsigned NDIG = 8
) (
  input  dcode_t [NDIG-1:0] x_i,
  input  dcode_t [NDIG-1:0] y_i,
  output dval_t  [NDIG-1:0] t_o,
  output dval_t  [NDIG-1:0] w_o
);
  for (genvar i = 0; i < NDIG; i++) begin : g_dig
    dval_t s;
    tw_t   tw;
    assign s      = dig_dec(x_i[i]) + dig_dec(y_i[i]);
    assign tw     = split_pair(s);
    assign t_o[i] = tw.t;
    assign w_o[i] = tw.w;

    always_comb begin
      if (!$isunknown({x_i[i], y_i[i]})) begin
        a_r3_pair_weight: assert (2 * int'(tw.t) + int'(tw.w)
                                  == int'(dig_dec(x_i[i])) + int'(dig_dec(y_i[i])));
      end
    end
  end
endmodule

// File: rtl/msd_rebal_stage.sv
module msd_rebal_stage import msd_pkg::*; #(
  parameter int unsigned NDIG = 9
) (
  input  dval_t [NDIG-2:0] t_i,
  input  dval_t [NDIG-1:0] w_i,
  output dval_t [NDIG-1:0] t1_o,
  output dval_t [NDIG-1:0] w1_o
);
  for (genvar i = 0; i < NDIG; i++) begin : g_dig
    dval_t s;
    tw_t   tw;
    if (i == 0) begin : g_lsd
      assign s = dval_t'(w_i[i]);
    end else begin : g_upper
      assign s = dval_t'(w_i[i]) + dval_t'(t_i[i-1]);
    end
    assign tw      = split_sum(s);
    assign t1_o[i] = tw.t;
    assign w1_o[i] = tw.w;

    always_comb begin
      if (!$isunknown(s)) begin
        a_r4_sum_span: assert (s >= -3'sd2 && s <= 3'sd2);
        a_r4_rebal_value: assert (2 * int'(tw.t) + int'(tw.w) == int'(s));
        a_r4_single_nonzero: assert (tw.t == 3'sd0 || tw.w == 3'sd0);
      end
    end
  end
endmodule

// File: rtl/msd_sum_stage.sv
module msd_sum_stage import msd_pkg::*; #(
  parameter int unsigned NDIG = 9
) (
  input  dval_t  [NDIG-2:0] t1_i,
  input  dval_t  [NDIG-1:0] w1_i,
  output dcode_t [NDIG-1:0] z_o
);
  for (genvar i = 0; i < NDIG; i++) begin : g_dig
    dval_t s;
    if (i == 0) begin : g_lsd
      assign s = dval_t'(w1_i[i]);
    end else begin : g_upper
      assign s = dval_t'(w1_i[i]) + dval_t'(t1_i[i-1]);
    end
    assign z_o[i] = dig_enc(s);

    always_comb begin
      if (!$isunknown(s)) begin
        a_r1_digit_span: assert (s >= -3'sd1 && s <= 3'sd1);
        a_r1_legal_code: assert (z_o[i] != 2'b10);
      end
    end
  end
endmodule

// File: rtl/msd_adder.sv
module msd_adder import msd_pkg::*; #(
  parameter int unsigned N = 8
) (
  input  logic [2*N-1:0] x_i,
  input  logic [2*N-1:0] y_i,
  output logic [2*N+1:0] z_o
);
  localparam int unsigned NOUT = N + 1;

  dcode_t [N-1:0]    x_d, y_d;
  dval_t  [N-1:0]    t, w;
  dval_t  [NOUT-1:0] w_ext, t1, w1;
  dcode_t [NOUT-1:0] z_d;

  assign x_d   = x_i;
  assign y_d   = y_i;
  assign w_ext = {3'sd0, w};

  msd_xfer_stage #(.NDIG(N)) u_xfer (
    .x_i(x_d), .y_i(y_d), .t_o(t), .w_o(w)
  );

  msd_rebal_stage #(.NDIG(NOUT)) u_rebal (
    .t_i(t), .w_i(w_ext), .t1_o(t1), .w1_o(w1)
  );

  msd_sum_stage #(.NDIG(NOUT)) u_sum (
    .t1_i(t1[N-1:0]), .w1_i(w1), .z_o(z_d)
  );

  assign z_o = z_d;

  // the top position only ever sees one transfer, so nothing leaves it
  always_comb begin
    if (!$isunknown({x_i, y_i})) begin
      a_r2_no_carry_out: assert (t1[N] == 3'sd0);
    end
  end
endmodule

// File: tb/tb_msd_adder.sv
module tb_msd_adder;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  logic [7:0]  x4 = '0, y4 = '0;
  logic [9:0]  z4;
  logic [31:0] x16 = '0, y16 = '0;
  logic [33:0] z16;

  msd_adder #(.N(4))  dut   (.x_i(x4),  .y_i(y4),  .z_o(z4));
  msd_adder #(.N(16)) dut16 (.x_i(x16), .y_i(y16), .z_o(z16));

  function automatic logic [1:0] cd(int v);
    return (v > 0) ? 2'b01 : (v < 0) ? 2'b11 : 2'b00;
  endfunction

  function automatic int dv(logic [33:0] v, int k);
    case (v[2*k +: 2])
      2'b01:   return 1;
      2'b11:   return -1;
      default: return 0;
    endcase
  endfunction

  function automatic longint val(logic [33:0] v, int nd);
    longint acc = 0;
    for (int k = 0; k < nd; k++) acc += longint'(dv(v, k)) * (longint'(1) << k);
    return acc;
  endfunction

  function automatic int bad(logic [33:0] v, int nd);
    int c = 0;
    for (int k = 0; k < nd; k++) if (v[2*k +: 2] == 2'b10) c++;
    return c;
  endfunction

  function automatic logic [7:0] vec4(int a);
    logic [7:0] v;
    int r = a;
    for (int k = 0; k < 4; k++) begin
      v[2*k +: 2] = cd((r % 3) - 1);
      r = r / 3;
    end
    return v;
  endfunction

  function automatic logic [31:0] rnd16();
    logic [31:0] v;
    for (int k = 0; k < 16; k++) v[2*k +: 2] = cd(int'($urandom_range(2)) - 1);
    return v;
  endfunction

  function automatic logic [31:0] neg16(logic [31:0] a);
    logic [31:0] v;
    for (int k = 0; k < 16; k++) v[2*k +: 2] = cd(-dv({2'b00, a}, k));
    return v;
  endfunction

  task automatic chk(string tag, longint act, longint exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic drive4(logic [7:0] a, logic [7:0] b);
    @(posedge clk);
    x4 = a;
    y4 = b;
    @(negedge clk);
  endtask

  task automatic drive16(logic [31:0] a, logic [31:0] b);
    @(posedge clk);
    x16 = a;
    y16 = b;
    @(negedge clk);
  endtask

  task automatic t_zero();  // R8
    drive4('0, '0);
    chk("R8 zero N=4", longint'(z4), 0);
    drive16('0, '0);
    chk("R8 zero N=16", longint'(z16), 0);
  endtask

  task automatic t_negation();  // R8
    for (int i = 0; i < 50; i++) begin
      logic [31:0] a;
      a = rnd16();
      drive16(a, neg16(a));
      chk("R8 negation", longint'(z16), 0);
    end
  endtask

  task automatic t_exhaustive4();  // R1, R2
    for (int a = 0; a < 81; a++) begin
      for (int b = 0; b < 81; b++) begin
        drive4(vec4(a), vec4(b));
        chk("R2 value N=4", val(z4, 5), val(x4, 4) + val(y4, 4));
        chk("R1 code N=4", bad(z4, 5), 0);
      end
    end
  endtask

  task automatic t_random16();  // R1, R2
    for (int i = 0; i < 3000; i++) begin
      drive16(rnd16(), rnd16());
      chk("R2 value N=16", val(z16, 17), val(x16, 16) + val(y16, 16));
      chk("R1 code N=16", bad(z16, 17), 0);
    end
  endtask

  task automatic t_stage1();  // R3
    int pa[6] = '{1, 1, 1, 0, 0, -1};
    int pb[6] = '{1, 0, -1, 0, -1, -1};
    for (int i = 0; i < 6; i++) begin
      int p, te, we, hi;
      p  = pa[i] + pb[i];
      te = (p > 0) ? 1 : (p < 0) ? -1 : 0;
      we = (p == 1) ? -1 : (p == -1) ? 1 : 0;
      drive4({6'b0, cd(pa[i])}, {6'b0, cd(pb[i])});
      chk("R3 transfer z1", dv(z4, 1), te);
      chk("R3 weight z0", dv(z4, 0), we);
      hi = 0;
      for (int k = 2; k < 5; k++) if (dv(z4, k) != 0) hi++;
      chk("R3 upper zero", hi, 0);
    end
  endtask

  task automatic t_stage2();  // R4
    drive4(8'b0000_0001, 8'b0);
    chk("R4 +1 z0", dv(z4, 0), -1);
    chk("R4 +1 z1", dv(z4, 1), 1);
    chk("R4 +1 upper", longint'(z4[9:4]), 0);
    drive4(8'b0000_0011, 8'b0);
    chk("R4 -1 z0", dv(z4, 0), 1);
    chk("R4 -1 z1", dv(z4, 1), -1);
    drive4(8'b0000_1101, 8'b0000_0001);
    chk("R4 +2 collide", longint'(z4), 0);
    drive4(8'b0000_0111, 8'b0000_0011);
    chk("R4 -2 collide", longint'(z4), 0);
  endtask

  task automatic t_lsd();  // R6
    for (int a = -1; a <= 1; a++) begin
      for (int b = -1; b <= 1; b++) begin
        logic [31:0] xa, yb;
        int e;
        xa = rnd16();
        yb = rnd16();
        xa[1:0] = cd(a);
        yb[1:0] = cd(b);
        e = (a + b == 1) ? -1 : (a + b == -1) ? 1 : 0;
        drive16(xa, yb);
        chk("R6 z0", dv(z16, 0), e);
      end
    end
  endtask

  task automatic t_top();  // R7
    for (int i = 0; i < 50; i++) begin
      logic [31:0] xa, yb;
      int top;
      xa = rnd16();
      yb = rnd16();
      drive16(xa, yb);
      top = dv(z16, 16);
      for (int k = 0; k < 14; k++) begin
        xa[2*k +: 2] = cd(int'($urandom_range(2)) - 1);
        yb[2*k +: 2] = cd(int'($urandom_range(2)) - 1);
      end
      drive16(xa, yb);
      chk("R7 top digit", dv(z16, 16), top);
    end
  endtask

  task automatic t_local();  // R5
    for (int i = 0; i < 200; i++) begin
      logic [31:0] xa, yb;
      logic [33:0] zb;
      int m, mism;
      xa = rnd16();
      yb = rnd16();
      drive16(xa, yb);
      zb = z16;
      m  = int'($urandom_range(15));
      xa[2*m +: 2] = cd(int'($urandom_range(2)) - 1);
      yb[2*m +: 2] = cd(int'($urandom_range(2)) - 1);
      drive16(xa, yb);
      mism = 0;
      for (int k = 0; k < 17; k++)
        if ((k < m || k > m + 2) && dv(z16, k) != dv(zb, k)) mism++;
      chk("R5 locality", mism, 0);
    end
  endtask

  initial begin
    repeat (2) @(posedge clk);
    t_zero();
    t_stage1();
    t_stage2();
    t_lsd();
    t_exhaustive4();
    t_random16();
    t_negation();
    t_top();
    t_local();
    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_tests++;
      n_fail++;
      $display("FAIL R2 watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule